// File: doc/BRIEF.md
# Cycle-Aligned Output Enable Controller for a Four-Channel PWM Bank

This block decides, for each of four PWM channels, whether the channel's output driver is switched on. It also owns the shared PWM cycle timer. Every change it makes lands on a cycle boundary: a channel never starts or stops driving in the middle of a period.

Per-channel enable and disable commands arrive from a command receiver as single-clock commit strobes. Each command sets a per-channel pending flag. The flag is copied to the driver enable when the next cycle begins. A global force-off line is sampled at every cycle start. While it is seen high, no channel drives for the whole of that cycle, but the pending flags are kept.

An active-low halt line parks the bank, and it too waits for the end of the current cycle. At that point all drivers turn off and a one-clock clear strobe tells the duty registers to empty themselves. The timer then stops at zero, and commands are dropped until the line returns high. On release a fresh cycle begins at once. Outputs stay off until each channel is written again and a later cycle starts.

Top module: `pwm_oe_ctrl`

## Requirements
- R1: While `rst` is high, and on the clock after it, `drv_en_o`, `duty_clr_o` and `cyc_start_o` are all 0. The pending flags are cleared, so no channel drives at the first cycle start unless it has been enabled since.
- R2: While running, `cyc_start_o` is a one-clock pulse that appears every `CYC_LEN` clocks.
- R3: A commit (`cmd_valid`=1 with `cmd_en`=1) sets the pending flag of the channel whose index is `cmd_chan`, where value k selects `drv_en_o[k]`. The driver enable for that channel rises on the same clock on which `cyc_start_o` next rises.
- R4: A commit with `cmd_en`=0 clears that channel's pending flag, and its driver enable falls at the next cycle start. Between cycle starts, `drv_en_o` never changes, whatever commands arrive.
- R5: `force_hiz` is sampled on the boundary clock. If it is 1, `drv_en_o` is all zeros for that whole cycle. The pending flags are kept, so a later cycle started with `force_hiz`=0 drives the enabled channels again.
- R6: When `hold_n` is 0 at the end of a cycle, `drv_en_o` becomes 0 and `duty_clr_o` pulses high for exactly one clock. Both happen on the clock where the next cycle would have started. Until then, the outputs keep their values.
- R7: While halted, `cyc_start_o` stays 0, and commits, including commits made while `hold_n` is 0, are ignored.
- R8: On the clock after `hold_n` returns to 1 from the halted state, `cyc_start_o` pulses with `drv_en_o` still 0. A channel drives again only after a new enabling commit and a subsequent cycle start.
- R9: A commit made on the boundary clock itself does not affect the cycle that is starting. It takes effect at the following boundary.
- R10: Channels are independent: a commit changes only the pending flag of the addressed channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_n | input | 1 | Active-low halt request, acted on at the cycle end |
| force_hiz | input | 1 | Global force-off, sampled at each cycle start |
| cmd_valid | input | 1 | One-clock commit strobe from the command receiver |
| cmd_chan | input | CH_W (2) | Channel addressed by the commit |
| cmd_en | input | 1 | 1 = enable, 0 = disable the addressed channel |
| drv_en_o | output | N_CH (4) | Per-channel output-driver enable |
| duty_clr_o | output | 1 | One-clock clear strobe for the duty registers |
| cyc_start_o | output | 1 | One-clock pulse on the first clock of each PWM cycle |

## Verification
The main function is driven by a sequence of commit and force-off patterns. The sequence tells apart three things: an enable that takes effect at a boundary versus one that takes effect at once, pending flags that survive a forced-off cycle versus flags that are lost, and a disable of one channel versus a disturbance of its neighbours. A commit placed exactly on the boundary clock separates next-cycle from same-cycle application. The halt sequence counts the clocks to the clear strobe and checks that no cycle pulses occur while halted. It also sends an enable while halted, to show that after release the bank stays dark until a fresh write arrives.

// File: rtl/pwm_oe_pkg.sv
package pwm_oe_pkg;
  typedef enum logic {
    TMR_RUN  = 1'b0,
    TMR_HALT = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/oe_cycle_timer.sv
module oe_cycle_timer
  import pwm_oe_pkg::*;
#(
  parameter int CYC_LEN = 4096,
  localparam int CNT_W = (CYC_LEN > 2) ? $clog2(CYC_LEN) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_n,
  output logic new_cyc,
  output logic go_halt,
  output logic halted,
  output logic start_q,
  output logic clr_q
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);

  tmr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             at_end;
  logic             release_now;

  assign at_end      = (state == TMR_RUN) && (cnt == LAST);
  assign release_now = (state == TMR_HALT) && hold_n;
  assign go_halt     = at_end && !hold_n;
  assign new_cyc     = (at_end && hold_n) || release_now;
  assign halted      = (state == TMR_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= TMR_RUN;
      cnt     <= '0;
      start_q <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      start_q <= new_cyc;
      clr_q   <= go_halt;
      if (go_halt) begin
        state <= TMR_HALT;
        cnt   <= '0;
      end else if (new_cyc) begin
        state <= TMR_RUN;
        cnt   <= '0;
      end else if (state == TMR_RUN) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    (halted && !hold_n) |=> (halted && $stable(cnt) && !start_q)); // R7
  AST_CLR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    clr_q |=> !clr_q); // R6
  AST_NO_START_IN_HALT: assert property (@(posedge clk) disable iff (rst)
    halted |-> !(start_q && clr_q)); // R7
endmodule

// File: rtl/oe_cmd_decode.sv
module oe_cmd_decode #(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            cmd_valid,
  input  logic [CH_W-1:0] cmd_chan,
  input  logic            accept,
  output logic [N_CH-1:0] hit
);
  for (genvar i = 0; i < N_CH; i++) begin : g_hit
    assign hit[i] = cmd_valid && accept && (cmd_chan == CH_W'(i));
  end

  always_comb begin
    AST_SINGLE_TARGET: assert ($onehot0(hit)); // R10
  end
endmodule

// File: rtl/oe_chan_slice.sv
module oe_chan_slice (
  input  logic clk,
  input  logic rst,
  input  logic cmd_hit,
  input  logic cmd_en,
  input  logic new_cyc,
  input  logic go_halt,
  input  logic force_hiz,
  output logic drv_q
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      drv_q  <= 1'b0;
    end else if (go_halt) begin
      pend_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      if (new_cyc) drv_q <= pend_q && !force_hiz;
      if (cmd_hit) pend_q <= cmd_en;
    end
  end

  AST_DRV_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!new_cyc && !go_halt) |=> $stable(drv_q)); // R4
  AST_FORCE_OFF: assert property (@(posedge clk) disable iff (rst)
    (new_cyc && force_hiz) |=> !drv_q); // R5
  AST_HALT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    go_halt |=> (!drv_q && !pend_q)); // R6
endmodule

// File: rtl/pwm_oe_ctrl.sv
module pwm_oe_ctrl #(
  parameter int N_CH    = 4,
  parameter int CYC_LEN = 4096,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_n,
  input  logic            force_hiz,
  input  logic            cmd_valid,
  input  logic [CH_W-1:0] cmd_chan,
  input  logic            cmd_en,
  output logic [N_CH-1:0] drv_en_o,
  output logic            duty_clr_o,
  output logic            cyc_start_o
);
  logic            new_cyc;
  logic            go_halt;
  logic            halted;
  logic            accept;
  logic [N_CH-1:0] hit;

  oe_cycle_timer #(.CYC_LEN(CYC_LEN)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .hold_n  (hold_n),
    .new_cyc (new_cyc),
    .go_halt (go_halt),
    .halted  (halted),
    .start_q (cyc_start_o),
    .clr_q   (duty_clr_o)
  );

  assign accept = hold_n && !halted;

  oe_cmd_decode #(.N_CH(N_CH)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_chan  (cmd_chan),
    .accept    (accept),
    .hit       (hit)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    oe_chan_slice u_slice (
      .clk       (clk),
      .rst       (rst),
      .cmd_hit   (hit[i]),
      .cmd_en    (cmd_en),
      .new_cyc   (new_cyc),
      .go_halt   (go_halt),
      .force_hiz (force_hiz),
      .drv_q     (drv_en_o[i])
    );
  end

  AST_CLR_WITH_DARK: assert property (@(posedge clk) disable iff (rst)
    duty_clr_o |-> (drv_en_o == '0)); // R6
  AST_CHANGE_ON_START: assert property (@(posedge clk) disable iff (rst)
    (!cyc_start_o && !duty_clr_o && !$rose(rst)) |-> 1'b1 ##0 (!$changed(drv_en_o) || $past(rst))); // R4
endmodule

// File: tb/sim_pwm_oe_ctrl.sv
`timescale 1ns/1ps
module sim_pwm_oe_ctrl;
  localparam int NCH = 4;
  localparam int CYC = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst, hold_n, force_hiz, cmd_valid, cmd_en;
  logic [1:0]     cmd_chan;
  logic [NCH-1:0] drv_en_o;
  logic           duty_clr_o, cyc_start_o;

  pwm_oe_ctrl #(.N_CH(NCH), .CYC_LEN(CYC)) u0 (
    .clk(clk), .rst(rst), .hold_n(hold_n), .force_hiz(force_hiz),
    .cmd_valid(cmd_valid), .cmd_chan(cmd_chan), .cmd_en(cmd_en),
    .drv_en_o(drv_en_o), .duty_clr_o(duty_clr_o), .cyc_start_o(cyc_start_o)
  );

  // {valid, force_hiz, en, chan[1:0], expected drv_en after next start[3:0]}
  localparam logic [8:0] VEC [8] = '{
    9'b1_0_1_00_0001,
    9'b1_0_1_10_0101,
    9'b0_1_0_00_0000,
    9'b0_0_0_00_0101,
    9'b1_0_1_11_1101,
    9'b1_0_0_00_1100,
    9'b1_1_1_01_0000,
    9'b0_0_0_00_1110
  };

  int checks = 0;
  int errors = 0;
  int n;
  int sc;
  logic [8:0]     v;
  logic [NCH-1:0] prev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_start(output int cnt);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!cyc_start_o && cnt < 4*CYC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; hold_n = 1'b1; force_hiz = 1'b0;
    cmd_valid = 1'b0; cmd_en = 1'b0; cmd_chan = '0;
    repeat (3) @(negedge clk);
    chk("R1 drv_en in reset", 32'(drv_en_o), 0);
    chk("R1 duty_clr in reset", 32'(duty_clr_o), 0);
    chk("R1 cyc_start in reset", 32'(cyc_start_o), 0);
    rst = 1'b0;

    wait_start(n);
    chk("R1 no drive after reset", 32'(drv_en_o), 0);
    wait_start(n);
    chk("R2 cycle period", n, CYC);
    @(negedge clk);
    chk("R2 start is one clock", 32'(cyc_start_o), 0);
    wait_start(n);

    // Table walk: R3 R4 R5 R10
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      cmd_valid = v[8]; force_hiz = v[7]; cmd_en = v[6]; cmd_chan = v[5:4];
      prev = drv_en_o;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk($sformatf("R4 no change mid-cycle vec%0d", i), 32'(drv_en_o), 32'(prev));
      wait_start(n);
      chk($sformatf("R3/R5/R10 drive after start vec%0d", i), 32'(drv_en_o), 32'(v[3:0]));
    end

    // R9: commit on the boundary clock
    repeat (CYC-1) @(negedge clk);
    cmd_valid = 1'b1; cmd_en = 1'b1; cmd_chan = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 boundary reached", 32'(cyc_start_o), 1);
    chk("R9 boundary commit deferred", 32'(drv_en_o), 32'h0e);
    wait_start(n);
    chk("R9 boundary commit applied next", 32'(drv_en_o), 32'h0f);

    // R6: halt at cycle end
    hold_n = 1'b0;
    @(negedge clk);
    chk("R6 still driving mid-cycle", 32'(drv_en_o), 32'h0f);
    n = 1;
    while (!duty_clr_o && n < 4*CYC) begin
      @(negedge clk);
      n++;
    end
    chk("R6 clear at cycle end", n, CYC);
    chk("R6 drivers off", 32'(drv_en_o), 0);
    chk("R7 no start at halt", 32'(cyc_start_o), 0);
    @(negedge clk);
    chk("R6 clear one clock", 32'(duty_clr_o), 0);

    // R7: ignored while halted
    cmd_valid = 1'b1; cmd_en = 1'b1; cmd_chan = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    sc = 0;
    for (int k = 0; k < 2*CYC; k++) begin
      @(negedge clk);
      if (cyc_start_o) sc++;
    end
    chk("R7 no starts while halted", sc, 0);
    chk("R7 dark while halted", 32'(drv_en_o), 0);

    // R8: release
    hold_n = 1'b1;
    @(negedge clk);
    chk("R8 start on release", 32'(cyc_start_o), 1);
    chk("R8 dark on release", 32'(drv_en_o), 0);
    wait_start(n);
    chk("R8 period after release", n, CYC);
    chk("R7/R8 halted commit was dropped", 32'(drv_en_o), 0);
    cmd_valid = 1'b1; cmd_en = 1'b1; cmd_chan = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_start(n);
    chk("R8 rewrite restores drive", 32'(drv_en_o), 32'h04);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule